// File: doc/BRIEF.md
# SPI Event and Receive-Port Status Unit

This unit is the status and interrupt block of an SPI master whose data paths run through byte FIFOs. The serial engine pushes received bytes into a 32-byte receive FIFO inside the unit. The transmit FIFO lives elsewhere and reports its fill level to the unit. The unit folds both fill levels, a set of sticky condition flags and a transaction-done event into one 32-bit event word. A mask register selects which flags drive the single interrupt line.

Software reaches the unit through a small word-addressed register port: word 0 holds the thresholds, word 1 is the event word, word 2 is the mask and word 3 is the receive data port. Read data is a combinational function of the current state and `regAddr`. A read of word 3 pops bytes at the clock edge where `regRd` is high. A full-width read returns up to four bytes packed with the oldest byte on top. A byte read returns one byte.

Top module: `spiEventUnit`

## Requirements
- R1: The event word carries the receive byte count in bits 29:24, the transmit level in bits 21:16, and the flags at these positions: transmit-empty 15, done 14, receive-threshold 13, receive-full 12, transmit-threshold 11, receive-not-empty 9, transmit-not-full 8. All other bits read zero. Both counts are live.
- R2: The four level flags are set at the clock edge after their condition holds. The conditions are transmit level 0, receive count 32, receive count nonzero, and transmit level not 32. Each flag then stays set until cleared. A clear has no effect while its condition still holds.
- R3: Word 0 holds the transmit threshold in bits 13:8 and the receive threshold in bits 5:0. Receive-threshold is set when the receive count exceeds the receive threshold. Transmit-threshold is set when the free space (32 minus the transmit level) is at least the transmit threshold. Both follow the sticky rule of R2.
- R4: A one-cycle `doneIn` pulse sets the done flag at the next edge. The flag stays set until cleared. A clear in the same cycle as a pulse leaves it set.
- R5: Writing word 1 clears exactly the flags whose bits are written as one. Zero bits leave flags untouched. Writing all ones clears every flag whose condition is false.
- R6: Word 2 is the mask. Only the seven flag positions are stored, and all other bits read zero. `irq` is high exactly when some flag and its mask bit are both set.
- R7: A full-width read of word 3 (`regSize8`=0) returns the oldest available byte in bits 31:24, then the next bytes below it. Up to four bytes are returned, with unused lower bytes zero. The read pops min(4, count) bytes.
- R8: A byte read of word 3 (`regSize8`=1) returns the oldest byte in bits 7:0, with the upper bits zero, and pops one byte. On an empty FIFO, either read returns zero and pops nothing.
- R9: A push when the count is 32 is dropped, even if a read pops in the same cycle. Otherwise a push and a pop in one cycle both take effect. The count never exceeds 32.
- R10: While `rstN` is low, all flags are clear, the mask is zero, the receive count is zero and the thresholds are 4 (transmit) and 3 (receive).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regWr | input | 1 | Register write strobe |
| regRd | input | 1 | Register read strobe (pops on word 3) |
| regAddr | input | 2 | Word select: 0 thresholds, 1 events, 2 mask, 3 receive port |
| regSize8 | input | 1 | Byte-wide access to the receive port |
| regWdata | input | 32 | Write data |
| regRdata | output | 32 | Read data for the selected word |
| rxPush | input | 1 | Serial engine delivers a received byte |
| rxPushData | input | 8 | Received byte |
| txLevel | input | 6 | Live transmit FIFO byte count |
| doneIn | input | 1 | Transaction-done pulse |
| eventWord | output | 32 | Current event word |
| irq | output | 1 | Masked interrupt request |

## Verification
A corrupted FIFO pointer or count shows up at the ports at once. The count field of the event word, and the packed bytes on a receive-port read, stop matching the byte order of the pushes. A flag that is dropped or stuck is seen one edge after its cause, either in the event word or through `irq` once the bit is unmasked. A reference model updated every cycle flags any mismatch on the same clock. Sticky-versus-live distinctions are probed by clearing flags both while their condition holds and after it has gone.

// File: rtl/spiEvtPkg.sv
package spiEvtPkg;
  localparam int EVT_TXE = 15;
  localparam int EVT_DON = 14;
  localparam int EVT_RXT = 13;
  localparam int EVT_RXF = 12;
  localparam int EVT_TXT = 11;
  localparam int EVT_RNE = 9;
  localparam int EVT_TNF = 8;
  localparam logic [31:0] FLAG_BITS = 32'h0000_FB00;

  localparam logic [1:0] ADDR_MODE   = 2'd0;
  localparam logic [1:0] ADDR_EVENT  = 2'd1;
  localparam logic [1:0] ADDR_MASK   = 2'd2;
  localparam logic [1:0] ADDR_RXPORT = 2'd3;

  typedef struct packed {
    logic       modeWr;
    logic       maskWr;
    logic       evtClr;
    logic [2:0] popCnt;
  } ctrlStrobe_t;
endpackage

// File: rtl/spiEvtCtrl.sv
module spiEvtCtrl
  import spiEvtPkg::*;
#(
  parameter int CNT_W = 6
) (
  input  logic             regWr,
  input  logic             regRd,
  input  logic [1:0]       regAddr,
  input  logic             regSize8,
  input  logic [CNT_W-1:0] rxLevel,
  output ctrlStrobe_t      strb
);
  always_comb begin
    strb = '0;
    if (regWr) begin
      case (regAddr)
        ADDR_MODE:  strb.modeWr = 1'b1;
        ADDR_EVENT: strb.evtClr = 1'b1;
        ADDR_MASK:  strb.maskWr = 1'b1;
        default:    strb.modeWr = 1'b0;
      endcase
    end
    if (regRd && regAddr == ADDR_RXPORT) begin
      if (regSize8) strb.popCnt = (rxLevel != '0) ? 3'd1 : 3'd0;
      else          strb.popCnt = (32'(rxLevel) >= 4) ? 3'd4 : rxLevel[2:0];
    end
  end
endmodule

// File: rtl/spiEvtDatapath.sv
module spiEvtDatapath
  import spiEvtPkg::*;
#(
  parameter int DEPTH = 32,
  parameter int THR_W = 6,
  parameter int TX_THR_RST = 4,
  parameter int RX_THR_RST = 3,
  localparam int CNT_W = $clog2(DEPTH + 1),
  localparam int PTR_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rstN,
  input  ctrlStrobe_t      strb,
  input  logic [1:0]       regAddr,
  input  logic             regSize8,
  input  logic [31:0]      regWdata,
  input  logic             rxPush,
  input  logic [7:0]       rxPushData,
  input  logic [CNT_W-1:0] txLevel,
  input  logic             doneIn,
  output logic [CNT_W-1:0] rxLevel,
  output logic [31:0]      eventWord,
  output logic [31:0]      regRdata,
  output logic             irq
);
  logic [7:0]       mem [DEPTH];
  logic [PTR_W-1:0] wrPtr, rdPtr;
  logic [CNT_W-1:0] levelQ;
  logic [THR_W-1:0] txThrQ, rxThrQ;
  logic [31:0]      flagsQ, maskQ, liveSet, clrVec;
  logic [CNT_W:0]   txFree;
  logic             pushOk;
  logic [7:0]       headByte [4];

  assign pushOk = rxPush && (levelQ != CNT_W'(DEPTH));
  assign txFree = (CNT_W+1)'(DEPTH) - {1'b0, txLevel};
  assign rxLevel = levelQ;

  always_comb begin
    liveSet = '0;
    liveSet[EVT_TXE] = (txLevel == '0);
    liveSet[EVT_RXF] = (levelQ == CNT_W'(DEPTH));
    liveSet[EVT_RNE] = (levelQ != '0);
    liveSet[EVT_TNF] = (txLevel != CNT_W'(DEPTH));
    liveSet[EVT_RXT] = (32'(levelQ) > 32'(rxThrQ));
    liveSet[EVT_TXT] = (32'(txFree) >= 32'(txThrQ));
  end

  assign clrVec = strb.evtClr ? (regWdata & FLAG_BITS) : '0;

  always_ff @(posedge clk) begin
    if (pushOk) mem[wrPtr] <= rxPushData;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr  <= '0;
      rdPtr  <= '0;
      levelQ <= '0;
      flagsQ <= '0;
      maskQ  <= '0;
      txThrQ <= THR_W'(TX_THR_RST);
      rxThrQ <= THR_W'(RX_THR_RST);
    end else begin
      if (pushOk) wrPtr <= wrPtr + 1'b1;
      rdPtr  <= rdPtr + PTR_W'(strb.popCnt);
      levelQ <= levelQ + CNT_W'(pushOk) - CNT_W'(strb.popCnt);
      flagsQ <= (flagsQ & ~clrVec) | liveSet | (doneIn ? (32'd1 << EVT_DON) : 32'd0);
      if (strb.maskWr) maskQ <= regWdata & FLAG_BITS;
      if (strb.modeWr) begin
        txThrQ <= regWdata[8 +: THR_W];
        rxThrQ <= regWdata[0 +: THR_W];
      end
    end
  end

  always_comb begin
    eventWord = flagsQ;
    eventWord[24 +: CNT_W] = levelQ;
    eventWord[16 +: CNT_W] = txLevel;
  end

  assign irq = |(flagsQ & maskQ);

  always_comb begin
    for (int k = 0; k < 4; k++) begin
      headByte[k] = (32'(levelQ) > k) ? mem[rdPtr + PTR_W'(k)] : 8'h00;
    end
    regRdata = '0;
    case (regAddr)
      ADDR_MODE: begin
        regRdata[8 +: THR_W] = txThrQ;
        regRdata[0 +: THR_W] = rxThrQ;
      end
      ADDR_EVENT: regRdata = eventWord;
      ADDR_MASK:  regRdata = maskQ;
      default: regRdata = regSize8 ? {24'h0, headByte[0]}
                                   : {headByte[0], headByte[1], headByte[2], headByte[3]};
    endcase
  end

  // R9
  level_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    32'(levelQ) <= DEPTH);
  // R8
  pop_within_level_chk: assert property (@(posedge clk) disable iff (!rstN)
    32'(strb.popCnt) <= 32'(levelQ));
  // R4
  done_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    doneIn |=> flagsQ[EVT_DON]);
  // R5
  done_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.evtClr && regWdata[EVT_DON] && !doneIn) |=> !flagsQ[EVT_DON]);
  // R2
  rne_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (levelQ != '0) |=> flagsQ[EVT_RNE]);
  // R6
  irq_masked_chk: assert property (@(posedge clk) disable iff (!rstN)
    (maskQ == '0) |-> !irq);
endmodule

// File: rtl/spiEventUnit.sv
module spiEventUnit
  import spiEvtPkg::*;
#(
  parameter int DEPTH = 32,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             regWr,
  input  logic             regRd,
  input  logic [1:0]       regAddr,
  input  logic             regSize8,
  input  logic [31:0]      regWdata,
  output logic [31:0]      regRdata,
  input  logic             rxPush,
  input  logic [7:0]       rxPushData,
  input  logic [CNT_W-1:0] txLevel,
  input  logic             doneIn,
  output logic [31:0]      eventWord,
  output logic             irq
);
  ctrlStrobe_t      strb;
  logic [CNT_W-1:0] rxLevel;

  spiEvtCtrl #(.CNT_W(CNT_W)) u_ctrl (
    .regWr(regWr), .regRd(regRd), .regAddr(regAddr), .regSize8(regSize8),
    .rxLevel(rxLevel), .strb(strb)
  );

  spiEvtDatapath #(.DEPTH(DEPTH)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .regAddr(regAddr), .regSize8(regSize8),
    .regWdata(regWdata), .rxPush(rxPush), .rxPushData(rxPushData),
    .txLevel(txLevel), .doneIn(doneIn), .rxLevel(rxLevel),
    .eventWord(eventWord), .regRdata(regRdata), .irq(irq)
  );
endmodule

// File: tb/spiEventUnit_tb.sv
module spiEventUnit_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWr, regRd, regSize8, rxPush, doneIn;
  logic [1:0]  regAddr;
  logic [31:0] regWdata, regRdata, eventWord;
  logic [7:0]  rxPushData;
  logic [5:0]  txLevel;
  logic        irq;

  int checks = 0;
  int errors = 0;
  string curReq = "R10";

  byte unsigned rxQ[$];
  logic [31:0] mFlags = 32'h0, mMask = 32'h0;
  logic [5:0]  mTxThr = 6'd4, mRxThr = 6'd3;

  always #10 clk = ~clk;

  spiEventUnit u_dut (
    .clk(clk), .rstN(rstN), .regWr(regWr), .regRd(regRd), .regAddr(regAddr),
    .regSize8(regSize8), .regWdata(regWdata), .regRdata(regRdata),
    .rxPush(rxPush), .rxPushData(rxPushData), .txLevel(txLevel),
    .doneIn(doneIn), .eventWord(eventWord), .irq(irq)
  );

  task automatic chk(string req, logic [31:0] got, logic [31:0] exp, string what);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, got, exp);
    end
  endtask

  function automatic logic [31:0] expEvent();
    logic [31:0] e = mFlags;
    e[29:24] = 6'(rxQ.size());
    e[21:16] = txLevel;
    return e;
  endfunction

  function automatic logic [31:0] expRd();
    byte unsigned b [4];
    for (int k = 0; k < 4; k++) b[k] = (k < rxQ.size()) ? rxQ[k] : 8'h00;
    case (regAddr)
      2'd0: return {18'h0, mTxThr, 2'b00, mRxThr};
      2'd1: return expEvent();
      2'd2: return mMask;
      default: return regSize8 ? {24'h0, b[0]} : {b[0], b[1], b[2], b[3]};
    endcase
  endfunction

  task automatic advanceModel();
    logic [31:0] live = 32'h0;
    logic [31:0] clr;
    int sz = rxQ.size();
    int n = 0;
    live[15] = (txLevel == 0);
    live[12] = (sz == 32);
    live[9]  = (sz != 0);
    live[8]  = (txLevel != 32);
    live[13] = (sz > int'(mRxThr));
    live[11] = ((32 - int'(txLevel)) >= int'(mTxThr));
    clr = (regWr && regAddr == 2'd1) ? (regWdata & 32'h0000_FB00) : 32'h0;
    mFlags = (mFlags & ~clr) | live | (doneIn ? 32'h0000_4000 : 32'h0);
    if (regRd && regAddr == 2'd3) n = regSize8 ? (sz > 0 ? 1 : 0) : (sz > 4 ? 4 : sz);
    repeat (n) void'(rxQ.pop_front());
    if (rxPush && sz < 32) rxQ.push_back(rxPushData);
    if (regWr && regAddr == 2'd0) begin
      mTxThr = regWdata[13:8];
      mRxThr = regWdata[5:0];
    end
    if (regWr && regAddr == 2'd2) mMask = regWdata & 32'h0000_FB00;
  endtask

  task automatic tick();
    #2;
    chk(curReq, eventWord, expEvent(), "eventWord");
    chk(curReq, {31'h0, irq}, {31'h0, |(mFlags & mMask)}, "irq");
    chk(curReq, regRdata, expRd(), "regRdata");
    if (rstN) advanceModel();
    @(negedge clk);
  endtask

  task automatic setIdle();
    regWr = 0; regRd = 0; regSize8 = 0; rxPush = 0; doneIn = 0;
    regAddr = 2'd1; regWdata = 32'h0; rxPushData = 8'h0;
  endtask

  task automatic wrReg(logic [1:0] a, logic [31:0] d);
    regWr = 1; regAddr = a; regWdata = d; tick(); setIdle();
  endtask

  task automatic pushByte(logic [7:0] b);
    rxPush = 1; rxPushData = b; tick(); setIdle();
  endtask

  task automatic portRead(logic sz8, logic [31:0] exp, string req);
    regRd = 1; regAddr = 2'd3; regSize8 = sz8; #1;
    chk(req, regRdata, exp, "port data");
    tick(); setIdle();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    setIdle(); txLevel = 6'd0; regAddr = 2'd0;
    @(negedge clk);
    // R10: reset values
    curReq = "R10";
    tick(); tick();
    chk("R10", regRdata, 32'h0000_0403, "reset thresholds");
    chk("R10", eventWord, 32'h0, "reset event");
    rstN = 1; setIdle();
    // R2: level flags after release
    curReq = "R2";
    tick();
    chk("R2", eventWord, 32'h0000_8900, "flags after release");
    // R1: counts merged with flags
    curReq = "R1";
    pushByte(8'hA1); pushByte(8'hB2); pushByte(8'hC3);
    txLevel = 6'd20; tick();
    chk("R1", eventWord, 32'h0314_8B00, "layout");
    // R6: mask storage and irq
    curReq = "R6";
    wrReg(2'd2, 32'hFFFF_FFFF);
    regAddr = 2'd2; #1; chk("R6", regRdata, 32'h0000_FB00, "mask readback"); tick();
    wrReg(2'd2, 32'h0000_4000);
    wrReg(2'd1, 32'hFFFF_FFFF);
    chk("R6", {31'h0, irq}, 32'h0, "irq masked off");
    // R4: done pulse and set-wins
    curReq = "R4";
    doneIn = 1; tick(); setIdle();
    chk("R4", {31'h0, irq}, 32'h1, "irq after done");
    doneIn = 1; regWr = 1; regAddr = 2'd1; regWdata = 32'h0000_4000; tick(); setIdle();
    chk("R4", {31'h0, eventWord[14]}, 32'h1, "set wins over clear");
    // R5: write-one-to-clear
    curReq = "R5";
    wrReg(2'd1, 32'h0000_4000);
    chk("R5", {31'h0, irq}, 32'h0, "done cleared");
    wrReg(2'd1, 32'h0000_0000);
    // R2: clear while condition holds
    curReq = "R2";
    wrReg(2'd1, 32'h0000_0200);
    chk("R2", {31'h0, eventWord[9]}, 32'h1, "not-empty held");
    // R3: thresholds
    curReq = "R3";
    wrReg(2'd0, 32'h0000_0D04);
    wrReg(2'd1, 32'hFFFF_FFFF);
    tick();
    chk("R3", {31'h0, eventWord[11]}, 32'h0, "tx threshold off");
    txLevel = 6'd19; tick(); tick();
    chk("R3", {31'h0, eventWord[11]}, 32'h1, "tx threshold on");
    pushByte(8'hD4); pushByte(8'hE5); tick();
    chk("R3", {31'h0, eventWord[13]}, 32'h1, "rx threshold on");
    // R7: full-width reads
    curReq = "R7";
    portRead(1'b0, 32'hA1B2_C3D4, "R7");
    portRead(1'b0, 32'hE500_0000, "R7");
    pushByte(8'h11); pushByte(8'h22); pushByte(8'h33);
    portRead(1'b0, 32'h1122_3300, "R7");
    // R8: byte reads and empty reads
    curReq = "R8";
    pushByte(8'h5A); pushByte(8'h6B);
    portRead(1'b1, 32'h0000_005A, "R8");
    portRead(1'b1, 32'h0000_006B, "R8");
    portRead(1'b1, 32'h0, "R8");
    portRead(1'b0, 32'h0, "R8");
    tick();
    chk("R8", {26'h0, eventWord[29:24]}, 32'h0, "empty count");
    // R9: overflow and simultaneous push/pop
    curReq = "R9";
    for (int i = 0; i < 33; i++) pushByte(8'(i + 8'h40));
    tick();
    chk("R9", {26'h0, eventWord[29:24]}, 32'd32, "full count");
    chk("R9", {31'h0, eventWord[12]}, 32'h1, "full flag");
    rxPush = 1; rxPushData = 8'hEE; regRd = 1; regAddr = 2'd3; regSize8 = 1; tick(); setIdle();
    chk("R9", {26'h0, eventWord[29:24]}, 32'd31, "push dropped at full");
    rxPush = 1; rxPushData = 8'h77; regRd = 1; regAddr = 2'd3; tick(); setIdle();
    chk("R9", {26'h0, eventWord[29:24]}, 32'd28, "push and pop");
    for (int i = 0; i < 7; i++) begin regRd = 1; regAddr = 2'd3; tick(); setIdle(); end
    curReq = "R5";
    txLevel = 6'd32;
    wrReg(2'd1, 32'hFFFF_FFFF);
    tick(); tick();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule